// File: doc/BRIEF.md
# Frame-Alternating Spread Code Generator

This block spreads a serial stream of data bits into a chip stream for a screen-to-camera optical link. Every data bit becomes eight binary chips taken from one of eight stored zero-correlation-duration codes. The codes form four sets, and each set is a pair. A 2-bit distance class picks the set. Within a video frame one code of the pair is used. On each frame-start strobe the generator moves to the other code of the pair, so a receiver can tell consecutive frames apart and drop a frame it captured twice.

The distance class is sampled only on a frame-start strobe. When the class changes, the new set starts again on its first code. The block also outputs the optical clock rate that belongs to the active set, so the renderer can pace its pattern updates. Input bits arrive on a valid/ready handshake. Output chips leave one per clock, and back-to-back bits produce a chip stream with no gaps.

Top module: `frame_code_spreader`

## Requirements
- R1: After reset code_idx_o is 0, chip_valid_o is 0, bit_ready_o is 1 and rate_hz_o is 30.
- R2: code_idx_o = {set, phase}. Let base row r be 4'b1110, 4'b1101, 4'b1011 or 4'b0111 for set 0 to 3. Phase 0 uses the 8-chip word {r, r} and phase 1 uses {r, ~r}. Bit 1 stands for chip +1 and bit 0 for chip -1. The word is sent most significant bit first.
- R3: A data bit of 1 sends the code word unchanged. A data bit of 0 sends the code word with every chip inverted.
- R4: The first frame-start strobe after reset loads the set from dist_class_i and sets the phase to 0.
- R5: A later strobe whose dist_class_i equals the current set toggles the phase.
- R6: A strobe whose dist_class_i differs from the current set loads the new set and sets the phase to 0.
- R7: code_idx_o changes only in the cycle after a clock edge at which frame_start_i was high.
- R8: rate_hz_o follows the current set: 0 gives 30, 1 gives 20, 2 gives 15 and 3 gives 10.
- R9: The chips of an accepted bit appear on the 8 cycles after the handshake, with chip_valid_o high. bit_ready_o is high when the block is idle or during the last chip of a bit, so a bit can be accepted there and the chips continue without a gap.
- R10: A bit is spread with the code shown on code_idx_o in its handshake cycle. A strobe while its chips are being sent does not alter them.
- R11: A change on dist_class_i without a strobe affects neither code_idx_o nor rate_hz_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame boundary strobe |
| dist_class_i | input | 2 | Receiver distance class |
| bit_valid_i | input | 1 | Data bit valid |
| bit_i | input | 1 | Data bit |
| bit_ready_o | output | 1 | Block can accept a data bit |
| chip_valid_o | output | 1 | chip_o carries a chip |
| chip_o | output | 1 | Spread chip, 1 = +1 |
| code_idx_o | output | 3 | Active code, {set, phase} |
| rate_hz_o | output | 5 | Optical clock rate of the active set in Hz |

## Verification
The bench goes after four hazards:
- A strobe at the same edge as a handshake, or in the middle of a bit. A design that latched the code too late would mix two codes inside one bit.
- A handshake during the last chip of a bit. A design without the early ready would leave a one-cycle gap, and one with an off-by-one counter would send seven or nine chips.
- The first strobe after reset. A design that toggled the phase there would start the first frame on code 01.
- A class change without a strobe. A design that did not hold the class would move code_idx_o and rate_hz_o in the middle of a frame.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int unsigned CHIP_LEN = 8;
  localparam int unsigned HALF_LEN = CHIP_LEN / 2;
  localparam int unsigned NUM_SETS = 4;
  localparam int unsigned SET_W    = $clog2(NUM_SETS);
  localparam int unsigned IDX_W    = SET_W + 1;
  localparam int unsigned RATE_W   = 5;

  typedef logic [CHIP_LEN-1:0] chip_word_t;
  typedef logic [SET_W-1:0]    set_t;

  function automatic logic [HALF_LEN-1:0] base_row(input int unsigned s);
    case (s)
      0:       return 4'b1110;
      1:       return 4'b1101;
      2:       return 4'b1011;
      default: return 4'b0111;
    endcase
  endfunction

  // phase 1 negates the second half: orthogonal partner of phase 0
  function automatic chip_word_t code_word(input int unsigned s, input int unsigned p);
    logic [HALF_LEN-1:0] r;
    r = base_row(s);
    return (p != 0) ? {r, ~r} : {r, r};
  endfunction

  function automatic logic [RATE_W-1:0] rate_for(input set_t s);
    case (s)
      2'd0:    return RATE_W'(30);
      2'd1:    return RATE_W'(20);
      2'd2:    return RATE_W'(15);
      default: return RATE_W'(10);
    endcase
  endfunction
endpackage

// File: rtl/frame_code_sel.sv
module frame_code_sel
  import fcs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  set_t dist_class_i,
  output set_t set_o,
  output logic phase_o
);
  logic started_q;
  set_t set_q;
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      set_q     <= '0;
      phase_q   <= 1'b0;
    end else if (frame_start_i) begin
      started_q <= 1'b1;
      if (!started_q || dist_class_i != set_q) begin
        set_q   <= dist_class_i;
        phase_q <= 1'b0;
      end else begin
        phase_q <= ~phase_q;
      end
    end
  end

  assign set_o   = set_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/code_rom.sv
module code_rom
  import fcs_pkg::*;
(
  input  set_t       set_i,
  input  logic       phase_i,
  output chip_word_t word_o
);
  localparam int unsigned ENTRIES = NUM_SETS * 2;

  chip_word_t rom [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign rom[g] = code_word(g / 2, g % 2);
  end

  assign word_o = rom[{set_i, phase_i}];
endmodule

// File: rtl/chip_serializer.sv
module chip_serializer #(
  parameter int unsigned CHIP_LEN = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_valid_i,
  input  logic                bit_i,
  input  logic [CHIP_LEN-1:0] word_i,
  output logic                bit_ready_o,
  output logic                chip_valid_o,
  output logic                chip_o
);
  localparam int unsigned CNT_W = $clog2(CHIP_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHIP_LEN - 1);

  logic                busy_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CHIP_LEN-1:0] sh_q;
  logic                last, take;

  assign last = busy_q && (cnt_q == LAST);
  assign bit_ready_o = !busy_q || last;
  assign take = bit_valid_i && bit_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      sh_q   <= word_i ^ {CHIP_LEN{~bit_i}};
    end else if (busy_q) begin
      sh_q  <= sh_q << 1;
      cnt_q <= cnt_q + CNT_W'(1);
      if (last) busy_q <= 1'b0;
    end
  end

  assign chip_valid_o = busy_q;
  assign chip_o       = sh_q[CHIP_LEN-1];
endmodule

// File: rtl/frame_code_spreader.sv
module frame_code_spreader
  import fcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [1:0]        dist_class_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  output logic              bit_ready_o,
  output logic              chip_valid_o,
  output logic              chip_o,
  output logic [2:0]        code_idx_o,
  output logic [4:0]        rate_hz_o
);
  set_t       set_w;
  logic       phase_w;
  chip_word_t word_w;

  frame_code_sel i_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .dist_class_i (dist_class_i),
    .set_o        (set_w),
    .phase_o      (phase_w)
  );

  code_rom i_rom (
    .set_i  (set_w),
    .phase_i(phase_w),
    .word_o (word_w)
  );

  chip_serializer #(.CHIP_LEN(CHIP_LEN)) i_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_valid_i (bit_valid_i),
    .bit_i       (bit_i),
    .word_i      (word_w),
    .bit_ready_o (bit_ready_o),
    .chip_valid_o(chip_valid_o),
    .chip_o      (chip_o)
  );

  assign code_idx_o = {set_w, phase_w};
  assign rate_hz_o  = rate_for(set_w);
endmodule

// File: rtl/frame_code_spreader_chk.sv
module frame_code_spreader_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_start_i,
  input logic [1:0] dist_class_i,
  input logic       bit_valid_i,
  input logic       bit_i,
  input logic       bit_ready_o,
  input logic       chip_valid_o,
  input logic       chip_o,
  input logic [2:0] code_idx_o,
  input logic [4:0] rate_hz_o
);
  logic [3:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         run_q <= '0;
    else if (bit_valid_i && bit_ready_o) run_q <= '0;
    else if (chip_valid_o)               run_q <= run_q + 4'd1;
  end

  assert_idx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(code_idx_o));

  assert_set_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> code_idx_o[2:1] == $past(dist_class_i));

  assert_phase_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && (dist_class_i != code_idx_o[2:1]) |=> !code_idx_o[0]);

  assert_rate_far_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_idx_o[2:1] == 2'd3) |-> (rate_hz_o == 5'd10));

  assert_rate_near_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_idx_o[2:1] == 2'd0) |-> (rate_hz_o == 5'd30));

  assert_chip_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_i && bit_ready_o |=> chip_valid_o);

  assert_no_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_valid_o && !bit_ready_o |=> chip_valid_o);

  assert_bit_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_valid_o && bit_ready_o |-> run_q == 4'd7);
endmodule

bind frame_code_spreader frame_code_spreader_chk i_chk (.*);

// File: tb/test_frame_code_spreader.sv
module test_frame_code_spreader;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_start_i = 1'b0;
  logic [1:0] dist_class_i = 2'd0;
  logic       bit_valid_i = 1'b0;
  logic       bit_i = 1'b0;
  logic       bit_ready_o, chip_valid_o, chip_o;
  logic [2:0] code_idx_o;
  logic [4:0] rate_hz_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  bit       m_started = 0;
  bit [1:0] m_set = 0;
  bit       m_phase = 0;
  bit       m_busy = 0;
  int       m_cnt = 0;
  bit [7:0] m_word = 0;

  always #4 clk_i = ~clk_i;

  frame_code_spreader i_frame_code_spreader (.*);

  function automatic bit [7:0] exp_code(bit [1:0] s, bit p);
    bit [3:0] r;
    r = ~(4'b0001 << s);
    return p ? {r, ~r} : {r, r};
  endfunction

  function automatic int exp_rate(bit [1:0] s);
    int t[4] = '{30, 20, 15, 10};
    return t[s];
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: compare at negedge, drive, advance model
  task automatic step(bit fs, bit [1:0] dc, bit v, bit b);
    bit rdy;
    @(negedge clk_i);
    rdy = !m_busy || (m_cnt == 7);
    check("R7 code_idx", int'(code_idx_o), int'({m_set, m_phase}));
    check("R8 rate", int'(rate_hz_o), exp_rate(m_set));
    check("R9 chip_valid", int'(chip_valid_o), int'(m_busy));
    check("R9 bit_ready", int'(bit_ready_o), int'(rdy));
    if (m_busy) check("R3 chip", int'(chip_o), int'(m_word[7 - m_cnt]));
    frame_start_i = fs; dist_class_i = dc; bit_valid_i = v; bit_i = b;
    // R10: word latched from the index shown now
    if (v && rdy) begin
      m_word = exp_code(m_set, m_phase) ^ {8{~b}};
      m_busy = 1; m_cnt = 0;
    end else if (m_busy) begin
      if (m_cnt == 7) m_busy = 0;
      m_cnt++;
    end
    if (fs) begin
      if (!m_started || dc != m_set) begin m_set = dc; m_phase = 0; end
      else m_phase = ~m_phase;
      m_started = 1;
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1: reset values
    check("R1 code_idx", int'(code_idx_o), 0);
    check("R1 chip_valid", int'(chip_valid_o), 0);
    check("R1 bit_ready", int'(bit_ready_o), 1);
    check("R1 rate", int'(rate_hz_o), 30);
    rst_ni = 1'b1;
    step(0, 2, 0, 0);            // R11: class moves, no strobe
    step(0, 3, 0, 0);
    step(1, 2, 0, 0);            // R4: first strobe, set 2 phase 0
    step(0, 2, 1, 1);            // bit on code 2/0 (R2)
    step(1, 2, 0, 0);            // R10: strobe mid-bit, R5 toggles
    for (int i = 0; i < 6; i++) step(0, 2, 1, 0);  // accept during last chip
    step(1, 2, 1, 1);            // strobe and handshake same edge
    step(1, 1, 0, 0);            // R6 class change mid-bit
    for (int i = 0; i < 20; i++) step(0, 0, 1, i[0]);
    step(1, 1, 0, 0);            // R5 toggle on set 1
    for (int i = 0; i < 10; i++) step(0, 1, 1, 1);
    for (int i = 0; i < 4000; i++) begin
      bit fs;
      bit [1:0] dc;
      fs = ($urandom_range(0, 29) == 0);
      dc = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : m_set;
      step(fs, dc, $urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)));
    end
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule